// File: doc/BRIEF.md
# DMA Controller Host Register File and Command Decoder

This block is the host-facing register file of a four-channel DMA controller. A host reads and writes it through a 4-bit register address, an active-low chip select and active-low read and write strobes. In the upper half of the address space, each address either accesses a register or triggers an action. Several read strobes have side effects: they set a flag or clear a counter instead of returning data. A single write address serves two purposes, and data bit 3 selects between them.

The block holds the following state:
- a command byte, a status byte, a request nibble and a temporary byte;
- one mode byte per channel, read back in turn through a rolling counter;
- a byte-pointer flag;
- four mask bits and four data-width bits.

The data-width bits are only reachable while the controller is in 16-bit transfer mode. A master clear, from software or from reset, returns the controller to 8-bit mode. A small stub interface stands in for the transfer engine. It can enter 16-bit mode, load the temporary byte and set status bits.

Strobes are sampled on the clock. Each strobe acts once, in the cycle its active level is first seen. Read data is latched into `dout` on that same edge.

Top module: `dma_regfile_top`

## Requirements
- R1: After reset, the outputs hold these values: mask is 4'hF, the command byte is 0, requests are 0, data-width bits are 0, 16-bit mode is off and the byte-pointer flag is 0. Status (read at 4'h8) and temporary (read at 4'hD) both return 8'h00.
- R2: A strobe counts only while cs_n is low and exactly one of rd_n and wr_n is low. A strobe held for several cycles acts once. Strobes with cs_n high, or with both rd_n and wr_n low, have no effect.
- R3: A write to 4'h8 loads the command byte, and a read of 4'hA returns it. A read of 4'h8 returns the status byte. Status bits accumulate from stat_set until a master clear.
- R4: A write to 4'h9 sets request bit din[1:0] to din[2]. A read of 4'h9 returns {4'b0, requests}.
- R5: A write to 4'hA, when din[3]=0 or the controller is in 8-bit mode, sets mask bit din[1:0] to din[2].
- R6: A write to 4'hA with din[3]=1 while in 16-bit mode loads the data-width bits from din[7:4] and leaves the mask unchanged. The data-width bits never change while in 8-bit mode.
- R7: A write to 4'hF loads mask from din[3:0]. A read of 4'hF returns {data-width bits, mask} in 16-bit mode and {4'b0, mask} in 8-bit mode.
- R8: A read strobe at 4'hC sets the byte-pointer flag and a write strobe at 4'hC clears it. Read strobes at 4'hC and 4'hE leave dout unchanged.
- R9: A write to 4'hB stores din into the mode byte of channel din[1:0]. Each read of 4'hB returns the mode byte of the channel the counter points at, then advances the counter, which wraps from 3 to 0. A read strobe at 4'hE resets the counter to channel 0.
- R10: A write strobe at 4'hE clears all four mask bits and leaves the data-width bits unchanged.
- R11: A write to 4'hD (master clear) has these effects:
  - it clears the command, status, request, temporary, byte-pointer and mode-counter state;
  - it sets the mask to 4'hF, leaves 16-bit mode and clears the data-width bits;
  - it keeps the mode bytes.
- R12: A tmp_load pulse stores tmp_data into the temporary byte, which a read of 4'hD returns.
- R13: Addresses 4'h0 to 4'h7 change no state here. Reads there return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as master clear |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, latched on the strobe's first edge |
| wide_enter | input | 1 | Stub: enter 16-bit transfer mode |
| tmp_load | input | 1 | Stub: load the temporary byte |
| tmp_data | input | 8 | Stub: low byte of the last word moved |
| stat_set | input | 8 | Stub: status bits to set |
| cmd_q | output | 8 | Command byte |
| req_q | output | 4 | Software request bits |
| mask_q | output | 4 | Channel mask bits |
| dw_q | output | 4 | Data-width bits |
| wide_q | output | 1 | 16-bit transfer mode active |
| ff_q | output | 1 | Byte-pointer flag |

## Verification
The bench first runs directed sequences, one per address, and then a long stream of random reads and writes over all sixteen addresses. Pulses from the stub interface are mixed into that stream. A shadow model predicts the effect of each operation.

The directed cases target the places where similar inputs must give different results:
- a write to 4'hA with data bit 3 set, once in 8-bit mode and once in 16-bit mode, which separates a mask write from a data-width write;
- a held strobe compared with repeated strobes, which separates one mode-counter advance from several;
- a strobe with both rd_n and wr_n low, and one with chip select high, neither of which may act;
- a master clear with programmed mode bytes present, which separates state the clear resets from state it keeps.

// File: rtl/dma_rf_pkg.sv
// Shared definitions for the DMA register file.
// Assumes the low three address bits select an operation in the upper space.
package dma_rf_pkg;

    typedef enum logic [2:0] {
        OP_STAT_CMD  = 3'b000,
        OP_REQ       = 3'b001,
        OP_CMD_MASK1 = 3'b010,
        OP_MODE      = 3'b011,
        OP_FLAG      = 3'b100,
        OP_TMP_MCLR  = 3'b101,
        OP_CNT_MCLR0 = 3'b110,
        OP_MASK_ALL  = 3'b111
    } reg_op_e;

endpackage

// File: rtl/dma_strobe_detect.sv
// Turns the asynchronous host strobes into single-cycle read and write events.
// Assumes the strobes are already synchronous to clk or held for at least two cycles.
module dma_strobe_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_ev,
    output logic wr_ev
);
    logic rd_lvl, wr_lvl, rd_q, wr_q;

    assign rd_lvl = !cs_n && !rd_n && wr_n;
    assign wr_lvl = !cs_n && !wr_n && rd_n;
    assign rd_ev  = rd_lvl && !rd_q;
    assign wr_ev  = wr_lvl && !wr_q;

    // Remember the previous qualified level so that only its first cycle acts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_lvl;
            wr_q <= wr_lvl;
        end
    end

    AST_ONE_RD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ev |=> !rd_ev);  // R2
    AST_ONE_WR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev |=> !wr_ev);  // R2

endmodule

// File: rtl/dma_ctrl_regs.sv
// Command, status, request, temporary, flag, mask and data-width state.
// Also decodes the master-clear action.
// Assumes rd_ev and wr_ev are single-cycle events that never occur together.
module dma_ctrl_regs
    import dma_rf_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_ev,
    input  logic           wr_ev,
    input  logic [3:0]     addr,
    input  logic [DW-1:0]  din,
    input  logic           wide_enter,
    input  logic           tmp_load,
    input  logic [DW-1:0]  tmp_data,
    input  logic [DW-1:0]  stat_set,
    output logic [DW-1:0]  cmd_q,
    output logic [DW-1:0]  stat_q,
    output logic [NCH-1:0] req_q,
    output logic [DW-1:0]  tmp_q,
    output logic           ff_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] dw_q,
    output logic           wide_q,
    output logic           mclr
);
    localparam int CH_W = $clog2(NCH);

    reg_op_e    op;
    logic       hi_space, wr_hit, rd_hit;
    logic [CH_W-1:0] ch_sel;

    assign op       = reg_op_e'(addr[2:0]);
    assign hi_space = addr[3];
    assign wr_hit   = wr_ev && hi_space;
    assign rd_hit   = rd_ev && hi_space;
    assign ch_sel   = din[CH_W-1:0];
    assign mclr     = wr_hit && (op == OP_TMP_MCLR);

    // Command byte: loaded by a write to the status/command address.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)                   cmd_q <= '0;
        else if (wr_hit && op == OP_STAT_CMD) cmd_q <= din;
    end

    // Status byte: accumulates bits reported by the transfer engine.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) stat_q <= '0;
        else                stat_q <= stat_q | stat_set;
    end

    // Request bits: a write sets or clears one channel.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)              req_q <= '0;
        else if (wr_hit && op == OP_REQ) req_q[ch_sel] <= din[2];
    end

    // Temporary byte: holds the last byte moved by the transfer engine.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) tmp_q <= '0;
        else if (tmp_load)  tmp_q <= tmp_data;
    end

    // Byte-pointer flag: a read strobe sets it, a write strobe clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)               ff_q <= 1'b0;
        else if (rd_hit && op == OP_FLAG) ff_q <= 1'b1;
        else if (wr_hit && op == OP_FLAG) ff_q <= 1'b0;
    end

    // 16-bit mode flag: entered from the stub, left only by master clear.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) wide_q <= 1'b0;
        else if (wide_enter) wide_q <= 1'b1;
    end

    // Mask and data-width bits: single, all-at-once and clear-all writes.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            mask_q <= '1;
            dw_q   <= '0;
        end else if (wr_hit) begin
            case (op)
                OP_CMD_MASK1: begin
                    if (wide_q && din[3]) dw_q <= din[DW-1 -: NCH];
                    else                  mask_q[ch_sel] <= din[2];
                end
                OP_CNT_MCLR0: mask_q <= '0;
                OP_MASK_ALL:  mask_q <= din[NCH-1:0];
                default: ;
            endcase
        end
    end

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask_q == '1 && !wide_q && cmd_q == '0 && req_q == '0 && !ff_q));  // R11
    AST_CLRMASK_KEEPS_DW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && op == OP_CNT_MCLR0) |=> (mask_q == '0 && $stable(dw_q)));  // R10
    AST_DW_FROZEN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_q |=> $stable(dw_q));  // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && op == OP_FLAG) |=> ff_q);  // R8

endmodule

// File: rtl/dma_mode_bank.sv
// Per-channel mode bytes with a rolling read-back counter.
// Assumes mode_rd and cnt_clr are single-cycle events; cnt_clr wins over mode_rd.
module dma_mode_bank #(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic          mode_rd,
    input  logic          cnt_clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_byte
);
    localparam int CH_W = $clog2(NCH);

    logic [DW-1:0]   mode_q [NCH];
    logic [CH_W-1:0] cnt_q;

    for (genvar i = 0; i < NCH; i++) begin : g_mode
        // Mode byte of channel i: written when the data selects this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    mode_q[i] <= '0;
            else if (mode_wr && din[CH_W-1:0] == CH_W'(i)) mode_q[i] <= din;
        end
    end

    // Read-back counter: advances after each mode read and wraps at the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) cnt_q <= '0;
        else if (mode_rd)      cnt_q <= (cnt_q == CH_W'(NCH - 1)) ? '0 : cnt_q + 1'b1;
    end

    assign rd_byte = mode_q[cnt_q];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && !cnt_clr) |=> (cnt_q == (($past(cnt_q) == CH_W'(NCH - 1)) ? '0 : $past(cnt_q) + 1'b1)));  // R9
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));  // R9

endmodule

// File: rtl/dma_regfile_top.sv
// Host register file and command decoder of a four-channel DMA controller.
// Assumes a synchronous host bus; read data is latched on the strobe's first edge.
module dma_regfile_top
    import dma_rf_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [3:0]     addr,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout,
    input  logic           wide_enter,
    input  logic           tmp_load,
    input  logic [DW-1:0]  tmp_data,
    input  logic [DW-1:0]  stat_set,
    output logic [DW-1:0]  cmd_q,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] dw_q,
    output logic           wide_q,
    output logic           ff_q
);
    localparam int PAD = DW - NCH;

    logic          rd_ev, wr_ev, mclr, mode_rd, mode_wr, cnt_clr;
    logic [DW-1:0] stat_q, tmp_q, mode_byte;
    reg_op_e       op;

    assign op      = reg_op_e'(addr[2:0]);
    assign mode_rd = rd_ev && addr[3] && op == OP_MODE;
    assign mode_wr = wr_ev && addr[3] && op == OP_MODE;
    assign cnt_clr = mclr || (rd_ev && addr[3] && op == OP_CNT_MCLR0);

    dma_strobe_detect u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .rd_ev (rd_ev),
        .wr_ev (wr_ev)
    );

    dma_ctrl_regs #(.DW(DW), .NCH(NCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ev      (rd_ev),
        .wr_ev      (wr_ev),
        .addr       (addr),
        .din        (din),
        .wide_enter (wide_enter),
        .tmp_load   (tmp_load),
        .tmp_data   (tmp_data),
        .stat_set   (stat_set),
        .cmd_q      (cmd_q),
        .stat_q     (stat_q),
        .req_q      (req_q),
        .tmp_q      (tmp_q),
        .ff_q       (ff_q),
        .mask_q     (mask_q),
        .dw_q       (dw_q),
        .wide_q     (wide_q),
        .mclr       (mclr)
    );

    dma_mode_bank #(.DW(DW), .NCH(NCH)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_rd (mode_rd),
        .cnt_clr (cnt_clr),
        .din     (din),
        .rd_byte (mode_byte)
    );

    // Read data latch: captures the addressed value on a read event; action reads hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (rd_ev) begin
            if (!addr[3]) begin
                dout <= '0;
            end else begin
                case (op)
                    OP_STAT_CMD:  dout <= stat_q;
                    OP_REQ:       dout <= {{PAD{1'b0}}, req_q};
                    OP_CMD_MASK1: dout <= cmd_q;
                    OP_MODE:      dout <= mode_byte;
                    OP_TMP_MCLR:  dout <= tmp_q;
                    OP_MASK_ALL:  dout <= {(wide_q ? dw_q : {NCH{1'b0}}), mask_q};
                    default: ;
                endcase
            end
        end
    end

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ev |=> $stable(dout));  // R8
    AST_LOW_SPACE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev && !addr[3]) |=> (dout == '0));  // R13

endmodule

// File: tb/tb_dma_regfile_top.sv
// Self-checking bench for dma_regfile_top: directed cases followed by seeded random traffic.
module tb_dma_regfile_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] din = '0, tmp_data = '0, stat_set = '0;
    logic       wide_enter = 1'b0, tmp_load = 1'b0;
    logic [7:0] dout, cmd_q;
    logic [3:0] req_q, mask_q, dw_q;
    logic       wide_q, ff_q;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Shadow model
    logic [7:0] m_cmd, m_stat, m_tmp, m_dout;
    logic [3:0] m_req, m_mask, m_dw;
    logic       m_wide, m_ff;
    logic [7:0] m_mode [4];
    logic [1:0] m_cnt;

    always #4 clk = ~clk;

    dma_regfile_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .wide_enter(wide_enter),
        .tmp_load(tmp_load), .tmp_data(tmp_data), .stat_set(stat_set),
        .cmd_q(cmd_q), .req_q(req_q), .mask_q(mask_q), .dw_q(dw_q),
        .wide_q(wide_q), .ff_q(ff_q)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        m_cmd = 0; m_stat = 0; m_req = 0; m_tmp = 0; m_ff = 0;
        m_cnt = 0; m_mask = 4'hF; m_wide = 0; m_dw = 0;
    endfunction

    function automatic void model_op(input bit is_rd, input logic [3:0] a, input logic [7:0] d);
        if (!a[3]) begin
            if (is_rd) m_dout = 8'h00;
            return;
        end
        case (a[2:0])
            3'd0: if (is_rd) m_dout = m_stat; else m_cmd = d;
            3'd1: if (is_rd) m_dout = {4'b0, m_req}; else m_req[d[1:0]] = d[2];
            3'd2: if (is_rd) m_dout = m_cmd;
                  else if (m_wide && d[3]) m_dw = d[7:4];
                  else m_mask[d[1:0]] = d[2];
            3'd3: if (is_rd) begin m_dout = m_mode[m_cnt]; m_cnt = m_cnt + 1; end
                  else m_mode[d[1:0]] = d;
            3'd4: m_ff = is_rd;
            3'd5: if (is_rd) m_dout = m_tmp; else model_clear();
            3'd6: if (is_rd) m_cnt = 0; else m_mask = 0;
            default: if (is_rd) m_dout = {m_wide ? m_dw : 4'b0, m_mask}; else m_mask = d[3:0];
        endcase
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " cmd"}, cmd_q, m_cmd);
        chk({tag, " req"}, {4'b0, req_q}, {4'b0, m_req});
        chk({tag, " mask"}, {4'b0, mask_q}, {4'b0, m_mask});
        chk({tag, " dw"}, {4'b0, dw_q}, {4'b0, m_dw});
        chk({tag, " wide/ff"}, {6'b0, wide_q, ff_q}, {6'b0, m_wide, m_ff});
        chk({tag, " dout"}, dout, m_dout);
    endtask

    // One host access: strobe low for one cycle, then released.
    task automatic bus(input bit is_rd, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; addr = a; din = d; rd_n = !is_rd; wr_n = is_rd;
        @(negedge clk);
        cs_n = 1; rd_n = 1; wr_n = 1;
        model_op(is_rd, a, d);
    endtask

    task automatic stub(input bit we, input bit tl, input logic [7:0] td, input logic [7:0] ss);
        @(negedge clk);
        wide_enter = we; tmp_load = tl; tmp_data = td; stat_set = ss;
        @(negedge clk);
        wide_enter = 0; tmp_load = 0; stat_set = 0;
        if (we) m_wide = 1;
        if (tl) m_tmp = td;
        m_stat = m_stat | ss;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (m_mode[i]) m_mode[i] = 0;
        model_clear(); m_dout = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset");
        bus(1, 4'h8, 0); chk("R1 status", dout, 8'h00);
        bus(1, 4'hD, 0); chk("R1 temp", dout, 8'h00);

        // R3 command and status
        bus(0, 4'h8, 8'hA5); bus(1, 4'hA, 0); check_state("R3 cmd");
        stub(0, 0, 0, 8'h12); stub(0, 0, 0, 8'h40);
        bus(1, 4'h8, 0); chk("R3 status", dout, 8'h52);
        // R4 request
        bus(0, 4'h9, 8'h06); bus(0, 4'h9, 8'h04); bus(1, 4'h9, 0); check_state("R4 req");
        // R5 single mask, bit 3 in 8-bit mode still masks
        bus(0, 4'hA, 8'h09); bus(0, 4'hA, 8'hFB); check_state("R5 mask1");
        // R6 data-width write in 16-bit mode
        stub(1, 0, 0, 0);
        bus(0, 4'hA, 8'hA8); check_state("R6 dw");
        bus(0, 4'hA, 8'h07); check_state("R6 mask in wide");
        // R7 all-mask write/read
        bus(0, 4'hF, 8'h36); bus(1, 4'hF, 0); check_state("R7 wide read");
        // R10 clear mask keeps dw
        bus(0, 4'hE, 0); check_state("R10 clrmask");
        // R8 flag, no dout change on action reads
        bus(1, 4'hC, 0); check_state("R8 set");
        bus(1, 4'hE, 0); check_state("R8 hold dout");
        bus(0, 4'hC, 0); check_state("R8 clear");
        // R9 mode bytes and counter
        for (int c = 0; c < 4; c++) bus(0, 4'hB, 8'h10 * (c + 1) + c[7:0] + 8'h04);
        for (int k = 0; k < 5; k++) begin bus(1, 4'hB, 0); check_state("R9 mode seq"); end
        bus(1, 4'hE, 0); bus(1, 4'hB, 0); check_state("R9 counter clear");
        // R2 held strobe advances once
        @(negedge clk); cs_n = 0; addr = 4'hB; rd_n = 0;
        repeat (3) @(negedge clk);
        cs_n = 1; rd_n = 1; model_op(1, 4'hB, 0);
        bus(1, 4'hB, 0); check_state("R2 held strobe");
        // R2 both strobes low, and chip select high
        @(negedge clk); cs_n = 0; addr = 4'hF; din = 8'h00; rd_n = 0; wr_n = 0;
        @(negedge clk); cs_n = 1; rd_n = 1; wr_n = 1;
        check_state("R2 dual strobe");
        @(negedge clk); cs_n = 1; addr = 4'hD; wr_n = 0;
        @(negedge clk); wr_n = 1;
        check_state("R2 no select");
        // R12 temporary byte
        stub(0, 1, 8'h3C, 0); bus(1, 4'hD, 0); check_state("R12 temp");
        // R13 low space
        bus(0, 4'h3, 8'hFF); bus(1, 4'h5, 0); check_state("R13 low space");
        // R11 master clear keeps mode bytes
        bus(0, 4'hD, 0); check_state("R11 mclr");
        bus(1, 4'hD, 0); chk("R11 temp", dout, 8'h00);
        bus(1, 4'hB, 0); check_state("R11 mode kept");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0) stub(r[4] & r[5], r[6], r[15:8], r[23:16] & 8'h11);
            else bus(r[4], r[11:8], r[23:16]);
            check_state("RND");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule